// File: doc/BRIEF.md
# AUX Channel Reply Status Decoder

This block sits after an auxiliary-channel transceiver and turns the state that the transceiver reports when a request completes into a single classified result. A request launch is signalled with `arm_i`. From then on, the block watches the completion flag, the hot-plug disconnect flag, the receiver error flags and the reply byte count. If completion never arrives, a bounded window timer ends the wait. A channel-level success leads to reading the reply byte stream. The first byte is the reply header. Its upper nibble is decoded into a reply kind: ACK, NACK, DEFER, I2C NACK, I2C DEFER or invalid.

The data bytes come only on an ACK. They are passed from the reply stream to a caller buffer stream, one byte per handshake, each tagged with its buffer index. The number of bytes forwarded is clipped to the buffer size. After the last byte, or straight after the header when no data is due, the block raises a one-cycle result pulse carrying the class, the reply kind and the number of bytes written. Both byte streams use valid/ready. The header byte is taken without regard to the sink. Data beats pass straight through, so back-pressure from the caller buffer reaches the reply source in the same cycle. The source drops any bytes beyond those the block consumes when the next request is armed. `buf_size_i` must be held stable from the header byte to the result pulse.

Top module: `aux_reply_decoder`

## Requirements
- R1: While awaiting completion, an asserted `hpd_discon_i` ends the transaction with class DISCON (3), whatever the other inputs are. It reports kind BAD (7) and 0 bytes.
- R2: When `done_i` is sampled and either `rx_tmo_i` or `rx_tmo_state_i` is set, the class is TIMEOUT (1), even if invalid-reply flags are also set.
- R3: When `done_i` is sampled without a timeout flag, any one of `rx_bad_stop_i`, `rx_no_det_i`, `rx_bad_hi_i`, `rx_bad_lo_i` gives class INVALID (2) with kind BAD and 0 bytes.
- R4: `rx_min_cnt_i` has no effect on the result or on the forwarded data.
- R5: A clean completion with `reply_cnt_i` equal to 0 gives class INVALID with 0 bytes and consumes no reply byte.
- R6: If `done_i` is not seen, the result pulse comes in the cycle after the TMO_CYCLES-th clock edge following the edge that samples `arm_i`, with class TIMEOUT. A `done_i` sampled on that last edge still wins.
- R7: After a clean completion, the first reply byte is taken with `rb_ready_o` high whatever `wb_ready_i` is. Its bits [7:4] select the kind: 0 is ACK (0), 1 is NACK (1), 2 is DEFER (2), 4 is I2C NACK (3), 8 is I2C DEFER (4), and any other value is BAD (7). Bits [3:0] are ignored. The class is OK (0).
- R8: Only on ACK are data bytes forwarded. The count is min(`reply_cnt_i` − 1, `buf_size_i`), with indices 0, 1, … in stream order and no byte changed. Every other kind reports 0 bytes.
- R9: During the data phase, `wb_valid_o` follows `rb_valid_i` and `rb_ready_o` follows `wb_ready_i`.
- R10: `res_valid_o` is high for exactly one cycle, the cycle after the last data-byte handshake (or after the header, or after the deciding status edge). It reports the number of bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Request launched; starts the completion window (ignored while busy) |
| buf_size_i | input | CNT_W | Caller buffer size in bytes |
| done_i | input | 1 | Transceiver completion flag |
| hpd_discon_i | input | 1 | Hot-plug disconnect flag |
| rx_tmo_state_i | input | 1 | Receiver timeout-state flag |
| rx_tmo_i | input | 1 | Receiver timeout flag |
| rx_bad_stop_i | input | 1 | Invalid stop condition flag |
| rx_no_det_i | input | 1 | Reply not detected flag |
| rx_bad_hi_i | input | 1 | Invalid high-level symbol flag |
| rx_bad_lo_i | input | 1 | Invalid low-level symbol flag |
| rx_min_cnt_i | input | 1 | Minimum-count violation flag (debug only) |
| reply_cnt_i | input | CNT_W | Reply byte count including the header byte |
| rb_valid_i | input | 1 | Reply byte stream valid |
| rb_data_i | input | 8 | Reply byte |
| rb_ready_o | output | 1 | Reply byte stream ready |
| wb_valid_o | output | 1 | Buffer write stream valid |
| wb_data_o | output | 8 | Byte to write |
| wb_idx_o | output | CNT_W | Buffer index of the byte |
| wb_ready_i | input | 1 | Buffer write stream ready |
| res_valid_o | output | 1 | One-cycle result pulse |
| res_class_o | output | 2 | 0 OK, 1 TIMEOUT, 2 INVALID, 3 DISCON |
| res_kind_o | output | 3 | Reply kind, encoded as in R7 |
| res_bytes_o | output | CNT_W | Number of data bytes written |

## Verification
The hardest case to reach is the boundary of the completion window. A completion flag that lands on the very edge where the timer expires must still count as success, and one cycle later it must be lost to the timeout. The stimulus reaches this by counting edges from the launch pulse and raising `done_i` with a delay of exactly TMO_CYCLES − 1 cycles. In the timeout-only case, the scoreboard also compares the cycle number of the result pulse. A second hard case is a disconnect raised together with timeout and invalid flags, which shows the priority order in a single sample. A pulsing sink ready exercises back-pressure on the data stream.

// File: rtl/aux_rsd_pkg.sv
package aux_rsd_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_INVALID = 2'd2,
    RES_DISCON  = 2'd3
  } res_class_t;

  typedef enum logic [2:0] {
    RK_ACK       = 3'd0,
    RK_NACK      = 3'd1,
    RK_DEFER     = 3'd2,
    RK_I2C_NACK  = 3'd3,
    RK_I2C_DEFER = 3'd4,
    RK_BAD       = 3'd7
  } reply_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_HDR    = 3'd2,
    ST_DATA   = 3'd3,
    ST_REPORT = 3'd4
  } dec_state_t;

  typedef struct packed {
    logic tmo_state;
    logic tmo;
    logic bad_stop;
    logic no_det;
    logic bad_hi;
    logic bad_lo;
    logic min_cnt;
  } rx_err_t;

endpackage

// File: rtl/aux_rsd_classify.sv
// Channel-level classification of a completion sample.
module aux_rsd_classify
  import aux_rsd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             hpd_i,
  input  logic             done_i,
  input  rx_err_t          err_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             finish_o,
  output logic             go_hdr_o,
  output res_class_t       cls_o
);

  logic tmo_hit;
  logic bad_hit;
  logic unused_min_cnt;

  assign tmo_hit = err_i.tmo | err_i.tmo_state;
  assign bad_hit = err_i.bad_stop | err_i.no_det | err_i.bad_hi | err_i.bad_lo;
  // debug-only flag, deliberately left out of the decision
  assign unused_min_cnt = err_i.min_cnt;

  always_comb begin
    finish_o = 1'b0;
    go_hdr_o = 1'b0;
    cls_o    = RES_OK;
    if (hpd_i) begin
      finish_o = 1'b1;
      cls_o    = RES_DISCON;
    end else if (done_i) begin
      if (tmo_hit) begin
        finish_o = 1'b1;
        cls_o    = RES_TIMEOUT;
      end else if (bad_hit || (cnt_i == '0)) begin
        finish_o = 1'b1;
        cls_o    = RES_INVALID;
      end else begin
        go_hdr_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/aux_rsd_cmd_decode.sv
// Reply header nibble to reply kind.
module aux_rsd_cmd_decode
  import aux_rsd_pkg::*;
(
  input  logic [3:0]  nib_i,
  output reply_kind_t kind_o
);

  always_comb begin
    unique case (nib_i)
      4'h0:    kind_o = RK_ACK;
      4'h1:    kind_o = RK_NACK;
      4'h2:    kind_o = RK_DEFER;
      4'h4:    kind_o = RK_I2C_NACK;
      4'h8:    kind_o = RK_I2C_DEFER;
      default: kind_o = RK_BAD;
    endcase
  end

endmodule

// File: rtl/aux_rsd_timer.sv
// Completion window: expires on the TMO_CYCLES-th cycle spent running.
module aux_rsd_timer #(
  parameter int TMO_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);

  localparam int TW = $clog2(TMO_CYCLES) + 1;
  localparam logic [TW-1:0] LAST = TW'(TMO_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/aux_rsd_fwd.sv
// Data beat count: clip, index and last-beat detection.
module aux_rsd_fwd #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] buf_i,
  input  logic             load_i,
  input  logic             beat_i,
  output logic [CNT_W-1:0] n_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);

  logic [CNT_W-1:0] avail;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] idx_q;

  assign avail = cnt_i - 1'b1;
  assign n_o   = (avail < buf_i) ? avail : buf_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      n_q   <= n_o;
      idx_q <= '0;
    end else if (beat_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == n_q - 1'b1);

endmodule

// File: rtl/aux_reply_decoder.sv
module aux_reply_decoder
  import aux_rsd_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int TMO_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] buf_size_i,
  input  logic             done_i,
  input  logic             hpd_discon_i,
  input  logic             rx_tmo_state_i,
  input  logic             rx_tmo_i,
  input  logic             rx_bad_stop_i,
  input  logic             rx_no_det_i,
  input  logic             rx_bad_hi_i,
  input  logic             rx_bad_lo_i,
  input  logic             rx_min_cnt_i,
  input  logic [CNT_W-1:0] reply_cnt_i,
  input  logic             rb_valid_i,
  input  logic [7:0]       rb_data_i,
  output logic             rb_ready_o,
  output logic             wb_valid_o,
  output logic [7:0]       wb_data_o,
  output logic [CNT_W-1:0] wb_idx_o,
  input  logic             wb_ready_i,
  output logic             res_valid_o,
  output logic [1:0]       res_class_o,
  output logic [2:0]       res_kind_o,
  output logic [CNT_W-1:0] res_bytes_o
);

  dec_state_t       st, st_nx;
  res_class_t       cls_q, cls_nx;
  reply_kind_t      kind_q, kind_nx;
  logic [CNT_W-1:0] bytes_q, bytes_nx;
  logic [CNT_W-1:0] cnt_q;

  rx_err_t          err;
  logic             c_finish, c_go_hdr;
  res_class_t       c_cls;
  reply_kind_t      hdr_kind;
  logic             tmr_exp;
  logic [CNT_W-1:0] fwd_n, fwd_idx;
  logic             fwd_last, fwd_load, beat, hdr_take;

  assign err = '{tmo_state: rx_tmo_state_i, tmo: rx_tmo_i,
                 bad_stop: rx_bad_stop_i, no_det: rx_no_det_i,
                 bad_hi: rx_bad_hi_i, bad_lo: rx_bad_lo_i,
                 min_cnt: rx_min_cnt_i};

  aux_rsd_classify #(.CNT_W(CNT_W)) u_cls (
    .hpd_i    (hpd_discon_i),
    .done_i   (done_i),
    .err_i    (err),
    .cnt_i    (reply_cnt_i),
    .finish_o (c_finish),
    .go_hdr_o (c_go_hdr),
    .cls_o    (c_cls)
  );

  aux_rsd_cmd_decode u_dec (
    .nib_i  (rb_data_i[7:4]),
    .kind_o (hdr_kind)
  );

  aux_rsd_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (st == ST_WAIT),
    .expired_o (tmr_exp)
  );

  aux_rsd_fwd #(.CNT_W(CNT_W)) u_fwd (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt_q),
    .buf_i  (buf_size_i),
    .load_i (fwd_load),
    .beat_i (beat),
    .n_o    (fwd_n),
    .idx_o  (fwd_idx),
    .last_o (fwd_last)
  );

  // stream edges
  assign rb_ready_o = (st == ST_HDR) || ((st == ST_DATA) && wb_ready_i);
  assign wb_valid_o = (st == ST_DATA) && rb_valid_i;
  assign wb_data_o  = rb_data_i;
  assign wb_idx_o   = fwd_idx;
  assign beat       = wb_valid_o && wb_ready_i;
  assign hdr_take   = (st == ST_HDR) && rb_valid_i;
  assign fwd_load   = hdr_take;

  always_comb begin
    st_nx    = st;
    cls_nx   = cls_q;
    kind_nx  = kind_q;
    bytes_nx = bytes_q;
    unique case (st)
      ST_IDLE: begin
        if (arm_i) st_nx = ST_WAIT;
      end
      ST_WAIT: begin
        if (c_finish) begin
          st_nx    = ST_REPORT;
          cls_nx   = c_cls;
          kind_nx  = RK_BAD;
          bytes_nx = '0;
        end else if (c_go_hdr) begin
          st_nx = ST_HDR;
        end else if (tmr_exp) begin
          st_nx    = ST_REPORT;
          cls_nx   = RES_TIMEOUT;
          kind_nx  = RK_BAD;
          bytes_nx = '0;
        end
      end
      ST_HDR: begin
        if (hdr_take) begin
          cls_nx  = RES_OK;
          kind_nx = hdr_kind;
          if ((hdr_kind == RK_ACK) && (fwd_n != '0)) begin
            st_nx    = ST_DATA;
            bytes_nx = fwd_n;
          end else begin
            st_nx    = ST_REPORT;
            bytes_nx = '0;
          end
        end
      end
      ST_DATA: begin
        if (beat && fwd_last) st_nx = ST_REPORT;
      end
      ST_REPORT: st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cls_q   <= RES_OK;
      kind_q  <= RK_BAD;
      bytes_q <= '0;
      cnt_q   <= '0;
    end else begin
      st      <= st_nx;
      cls_q   <= cls_nx;
      kind_q  <= kind_nx;
      bytes_q <= bytes_nx;
      if ((st == ST_WAIT) && c_go_hdr) cnt_q <= reply_cnt_i;
    end
  end

  assign res_valid_o = (st == ST_REPORT);
  assign res_class_o = cls_q;
  assign res_kind_o  = kind_q;
  assign res_bytes_o = bytes_q;

endmodule

// File: rtl/aux_reply_decoder_chk.sv
module aux_reply_decoder_chk
  import aux_rsd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input dec_state_t       st,
  input logic             done_i,
  input logic             hpd_discon_i,
  input logic             rx_tmo_i,
  input logic             rx_tmo_state_i,
  input logic [CNT_W-1:0] buf_size_i,
  input logic             rb_ready_o,
  input logic             wb_valid_o,
  input logic [CNT_W-1:0] wb_idx_o,
  input logic             wb_ready_i,
  input logic             res_valid_o,
  input logic [1:0]       res_class_o,
  input logic [2:0]       res_kind_o,
  input logic [CNT_W-1:0] res_bytes_o
);

  assert_disc_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && hpd_discon_i) |=> (res_valid_o && res_class_o == 2'd3));

  assert_tmo_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !hpd_discon_i && done_i && (rx_tmo_i || rx_tmo_state_i))
      |=> (res_valid_o && res_class_o == 2'd1));

  assert_clip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> (wb_idx_o < buf_size_i));

  assert_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_kind_o != 3'd0) |-> (res_bytes_o == '0));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !wb_ready_i) |-> !rb_ready_o);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

endmodule

bind aux_reply_decoder aux_reply_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .st             (st),
  .done_i         (done_i),
  .hpd_discon_i   (hpd_discon_i),
  .rx_tmo_i       (rx_tmo_i),
  .rx_tmo_state_i (rx_tmo_state_i),
  .buf_size_i     (buf_size_i),
  .rb_ready_o     (rb_ready_o),
  .wb_valid_o     (wb_valid_o),
  .wb_idx_o       (wb_idx_o),
  .wb_ready_i     (wb_ready_i),
  .res_valid_o    (res_valid_o),
  .res_class_o    (res_class_o),
  .res_kind_o     (res_kind_o),
  .res_bytes_o    (res_bytes_o)
);

// File: tb/aux_reply_decoder_test.sv
module aux_reply_decoder_test;

  localparam int CNT_W = 5;
  localparam int TMO   = 20;

  // flag vector bit positions used by the driver
  localparam int F_TMOST = 6, F_TMO = 5, F_STOP = 4, F_NODET = 3,
                 F_HI = 2, F_LO = 1, F_MIN = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0;
  logic [CNT_W-1:0] buf_size_i = '0;
  logic done_i = 1'b0, hpd_discon_i = 1'b0;
  logic [6:0] flags = '0;
  logic [CNT_W-1:0] reply_cnt_i = '0;
  logic rb_valid_i = 1'b0;
  logic [7:0] rb_data_i = '0;
  logic rb_ready_o, wb_valid_o, wb_ready_i, res_valid_o;
  logic [7:0] wb_data_o;
  logic [CNT_W-1:0] wb_idx_o, res_bytes_o;
  logic [1:0] res_class_o;
  logic [2:0] res_kind_o;

  always #10 clk = ~clk;

  aux_reply_decoder #(.CNT_W(CNT_W), .TMO_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .buf_size_i(buf_size_i),
    .done_i(done_i), .hpd_discon_i(hpd_discon_i),
    .rx_tmo_state_i(flags[F_TMOST]), .rx_tmo_i(flags[F_TMO]),
    .rx_bad_stop_i(flags[F_STOP]), .rx_no_det_i(flags[F_NODET]),
    .rx_bad_hi_i(flags[F_HI]), .rx_bad_lo_i(flags[F_LO]),
    .rx_min_cnt_i(flags[F_MIN]), .reply_cnt_i(reply_cnt_i),
    .rb_valid_i(rb_valid_i), .rb_data_i(rb_data_i), .rb_ready_o(rb_ready_o),
    .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o), .wb_idx_o(wb_idx_o),
    .wb_ready_i(wb_ready_i), .res_valid_o(res_valid_o),
    .res_class_o(res_class_o), .res_kind_o(res_kind_o), .res_bytes_o(res_bytes_o)
  );

  typedef struct {
    logic [1:0]       cls;
    logic [2:0]       kind;
    logic [CNT_W-1:0] bytes;
    int               cyc;
    string            tag;
  } exp_res_t;

  exp_res_t          exp_res[$];
  logic [7:0]        exp_wdat[$];
  logic [CNT_W-1:0]  exp_widx[$];

  int checks = 0, errors = 0, cyc = 0;
  bit bp_on = 1'b0, done_flag = 1'b0, prev_res = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // sink back-pressure, driven at the falling edge
  always @(negedge clk) wb_ready_i = bp_on ? ((cyc % 3) != 1) : 1'b1;

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (wb_valid_o) begin
        checks++;
        if (rb_ready_o !== wb_ready_i) begin
          errors++;
          $display("FAIL R9 rb_ready=%0b expected %0b", rb_ready_o, wb_ready_i);
        end
      end
      if (wb_valid_o && wb_ready_i) begin
        checks++;
        if (exp_wdat.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected write idx=%0d data=%02h expected none", wb_idx_o, wb_data_o);
        end else begin
          logic [7:0] d;
          logic [CNT_W-1:0] ix;
          d = exp_wdat.pop_front();
          ix = exp_widx.pop_front();
          if (wb_data_o !== d || wb_idx_o !== ix) begin
            errors++;
            $display("FAIL R8 write idx=%0d data=%02h expected idx=%0d data=%02h",
                     wb_idx_o, wb_data_o, ix, d);
          end
        end
      end
      if (res_valid_o && prev_res) begin
        checks++; errors++;
        $display("FAIL R10 result pulse two cycles, actual 1 expected 0");
      end
      if (res_valid_o) begin
        checks++;
        if (exp_res.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result class=%0d expected none", res_class_o);
        end else begin
          exp_res_t e;
          e = exp_res.pop_front();
          if (res_class_o !== e.cls || res_kind_o !== e.kind || res_bytes_o !== e.bytes) begin
            errors++;
            $display("FAIL %s class/kind/bytes=%0d/%0d/%0d expected %0d/%0d/%0d",
                     e.tag, res_class_o, res_kind_o, res_bytes_o, e.cls, e.kind, e.bytes);
          end
          if (e.cyc >= 0 && cyc != e.cyc) begin
            errors++;
            $display("FAIL %s result cycle %0d expected %0d", e.tag, cyc, e.cyc);
          end
          if (exp_wdat.size() != 0) begin
            errors++;
            $display("FAIL R10 result with %0d writes outstanding, expected 0", exp_wdat.size());
          end
        end
      end
      prev_res = res_valid_o;
    end
  end

  function automatic logic [2:0] ref_kind(input logic [3:0] n);
    case (n)
      4'h0: return 3'd0;
      4'h1: return 3'd1;
      4'h2: return 3'd2;
      4'h4: return 3'd3;
      4'h8: return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  task automatic send_byte(input logic [7:0] b);
    bit hs;
    rb_valid_i = 1'b1;
    rb_data_i  = b;
    do begin
      #5 hs = rb_ready_o;
      @(negedge clk);
    end while (!hs);
    rb_valid_i = 1'b0;
  endtask

  // driver: one request from launch to result
  task automatic txn(input string tag, input bit do_done, input bit hpd,
                     input logic [6:0] fl, input int cnt, input int bsz,
                     input logic [7:0] hdr, input int delay);
    exp_res_t e;
    int n = 0;
    bit ok = 1'b0;
    e.tag = tag; e.cyc = -1; e.kind = 3'd7; e.bytes = '0;
    if (hpd)                                     e.cls = 2'd3;
    else if (!do_done)                           e.cls = 2'd1;
    else if (fl[F_TMO] || fl[F_TMOST])           e.cls = 2'd1;
    else if (fl[F_STOP] || fl[F_NODET] || fl[F_HI] || fl[F_LO]) e.cls = 2'd2;
    else if (cnt == 0)                           e.cls = 2'd2;
    else begin
      ok = 1'b1;
      e.cls  = 2'd0;
      e.kind = ref_kind(hdr[7:4]);
      if (e.kind == 3'd0) n = ((cnt - 1) < bsz) ? (cnt - 1) : bsz;
      e.bytes = CNT_W'(n);
    end
    @(negedge clk);
    buf_size_i = CNT_W'(bsz);
    arm_i = 1'b1;
    if (!do_done && !hpd) e.cyc = cyc + TMO + 1;
    exp_res.push_back(e);
    for (int i = 0; i < n; i++) begin
      exp_wdat.push_back(8'(8'h3C ^ (i * 29) ^ cnt));
      exp_widx.push_back(CNT_W'(i));
    end
    @(negedge clk);
    arm_i = 1'b0;
    repeat (delay) @(negedge clk);
    if (do_done || hpd) begin
      done_i = do_done; hpd_discon_i = hpd; flags = fl; reply_cnt_i = CNT_W'(cnt);
      @(negedge clk);
      done_i = 1'b0; hpd_discon_i = 1'b0; flags = '0;
    end
    if (ok) begin
      send_byte(hdr);
      for (int i = 0; i < n; i++) send_byte(8'(8'h3C ^ (i * 29) ^ cnt));
    end
    while (exp_res.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired, actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    checks++;
    if (res_valid_o !== 1'b0 || wb_valid_o !== 1'b0 || rb_ready_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset outputs res/wb/rb=%0b%0b%0b expected 000",
               res_valid_o, wb_valid_o, rb_ready_o);
    end

    // R7 R8: ACK with data, then with a busy sink (R9)
    txn("R8_ack3", 1, 0, 7'b0, 4, 8, 8'h00, 2);
    bp_on = 1'b1;
    txn("R9_ack_bp", 1, 0, 7'b0, 7, 10, 8'h00, 1);
    // R8 clipping to the buffer size, and an empty buffer
    txn("R8_clip", 1, 0, 7'b0, 9, 3, 8'h05, 3);
    txn("R8_buf0", 1, 0, 7'b0, 5, 0, 8'h00, 1);
    bp_on = 1'b0;
    txn("R8_ack_nodata", 1, 0, 7'b0, 1, 8, 8'h0F, 1);
    // R7 reply kinds, low nibble ignored
    txn("R7_nack", 1, 0, 7'b0, 3, 8, 8'h10, 1);
    txn("R7_defer", 1, 0, 7'b0, 3, 8, 8'h2A, 1);
    txn("R7_i2c_nack", 1, 0, 7'b0, 2, 8, 8'h40, 0);
    txn("R7_i2c_defer", 1, 0, 7'b0, 2, 8, 8'h83, 0);
    txn("R7_bad3", 1, 0, 7'b0, 4, 8, 8'h30, 1);
    txn("R7_badF", 1, 0, 7'b0, 4, 8, 8'hF0, 1);
    // R2 timeout flags, one together with an invalid flag
    txn("R2_tmo", 1, 0, 7'b0100000, 4, 8, 8'h00, 2);
    txn("R2_tmo_state_over_invalid", 1, 0, 7'b1010000, 4, 8, 8'h00, 2);
    // R3 each invalid flag
    txn("R3_stop", 1, 0, 7'b0010000, 4, 8, 8'h00, 1);
    txn("R3_nodet", 1, 0, 7'b0001000, 4, 8, 8'h00, 1);
    txn("R3_hi", 1, 0, 7'b0000100, 4, 8, 8'h00, 1);
    txn("R3_lo", 1, 0, 7'b0000010, 4, 8, 8'h00, 1);
    // R4 min-count flag ignored
    txn("R4_mincnt", 1, 0, 7'b0000001, 3, 8, 8'h00, 1);
    // R5 zero count
    txn("R5_cnt0", 1, 0, 7'b0, 0, 8, 8'h00, 1);
    // R1 disconnect over everything, and without done
    txn("R1_hpd_all", 1, 1, 7'b1111111, 4, 8, 8'h00, 2);
    txn("R1_hpd_alone", 0, 1, 7'b0, 4, 8, 8'h00, 5);
    // R6 window expiry and the last-edge boundary
    txn("R6_expire", 0, 0, 7'b0, 0, 8, 8'h00, 0);
    txn("R6_done_last_edge", 1, 0, 7'b0, 3, 8, 8'h00, TMO - 1);

    checks++;
    if (exp_res.size() != 0 || exp_wdat.size() != 0) begin
      errors++;
      $display("FAIL R10 leftover results=%0d writes=%0d expected 0 0",
               exp_res.size(), exp_wdat.size());
    end
    summary();
  end

endmodule